// File: doc/BRIEF.md
# Autovectored Interrupt Priority Encoder

This block merges fourteen interrupt sources into one CPU interrupt request. The sources are the programmable, empty and full flags of four FIFO endpoints, plus two events from a waveform engine. Each source has a pending bit and an enable bit. The pending bit is set by a one-cycle event pulse and cleared by software through a write-one-to-clear strobe. The request line is raised while any source is both pending and enabled.

For a fast dispatch, the block also watches the CPU's code-fetch stream. The interrupt entry sits at code address 0x0053 and holds a jump instruction. The page byte of the jump target sits at 0x0054 and is never touched. When autovectoring is on, the block replaces the byte fetched from 0x0055 with a vector byte. That byte selects one of fourteen handler slots, four bytes apart. The vector is captured when the CPU fetches the entry address 0x0053, so the jump target stays stable for the rest of that instruction.

Top module: `avec_irq_top`

## Requirements
- R1: The source at bit i of every 14-bit source vector has priority i, with bit 0 the highest. Its vector byte is 0x80 + 4*i. The bits are assigned as follows: bits 0..3 are the programmable flags of endpoints 2, 4, 6 and 8; bits 4..7 are the empty flags of the same endpoints; bits 8..11 are their full flags; bit 12 is waveform-done; bit 13 is the waveform event.
- R2: A high `src_evt_i[i]` at a clock edge sets pending bit i. If `clr_i[i]` is high at the same edge, the set still wins.
- R3: A high `clr_i[i]` at a clock edge, with no event on that bit, clears pending bit i.
- R4: `irq_o` is registered. It is high one edge after the edge at which some pending bit and its enable bit are both 1.
- R5: A source whose enable bit is 0 does not raise `irq_o`. It also does not take part in the vector choice, even when it is pending.
- R6: The enable bits are loaded from `en_wdata_i` at an edge where `en_we_i` is high. Otherwise they hold their value.
- R7: When a valid fetch from 0x0053 occurs, the block captures the vector of the highest-priority source that is pending and enabled.
- R8: With `av_en_i` high, a valid fetch from 0x0055 makes `fetch_data_o` equal to the captured vector one edge later.
- R9: If no source is pending and enabled when the vector is captured, the captured vector is 0x80.
- R10: Events that arrive between the 0x0053 fetch and the 0x0055 fetch do not change the substituted byte.
- R11: With `av_en_i` low, every fetch passes `mem_data_i` through to `fetch_data_o` one edge later, including fetches from 0x0055.
- R12: Fetches from any address other than 0x0055 always pass through. This includes 0x0053 and 0x0054.
- R13: A synchronous reset clears all pending bits, all enable bits and `irq_o`, and sets the captured vector to 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | 14 | One-cycle event pulses, one per source |
| clr_i | input | 14 | Write-one-to-clear strobes for the pending bits |
| en_we_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | 14 | New enable mask |
| av_en_i | input | 1 | Autovector substitution enable |
| fetch_valid_i | input | 1 | A code fetch is presented this cycle |
| fetch_addr_i | input | 16 | Code fetch address |
| mem_data_i | input | 8 | Byte returned by code memory for this fetch |
| irq_o | output | 1 | Interrupt request to the CPU |
| fetch_data_o | output | 8 | Fetch byte to the CPU, possibly substituted |

## Verification
An event pulse sets its pending bit at the edge that samples it. `irq_o` follows one edge later, so the bench checks the request at the second falling edge after it drives the pulse. Fetch data is registered, so each fetch result is read at the falling edge after the rising edge that samples the address. The vector is captured at the edge that samples the 0x0053 fetch. The late-event test therefore pulses its higher-priority event only after that edge, and before it presents 0x0055.

// File: rtl/avec_pkg.sv
package avec_pkg;

  // Selects where the registered fetch byte comes from.
  typedef enum logic {
    FSEL_MEM = 1'b0,
    FSEL_VEC = 1'b1
  } fetch_sel_e;

  // Builds the vector byte for priority slot idx.
  function automatic logic [7:0] slot_vector(input logic [7:0] base,
                                             input logic [7:0] step,
                                             input int unsigned idx);
    logic [15:0] prod;
    prod = 16'(idx) * 16'(step);
    return base + prod[7:0];
  endfunction

endpackage

// File: rtl/avec_pending.sv
module avec_pending #(
  parameter int NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] en_o
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] en_q;

  // Each pending bit is its own set/clear flop. A set beats a clear.
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)                pend_q[g] <= 1'b0;
        else if (src_evt_i[g])  pend_q[g] <= 1'b1;
        else if (clr_i[g])      pend_q[g] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (src_evt_i != '0) |=> ((pend_q & $past(src_evt_i)) == $past(src_evt_i)));

  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~src_evt_i) != '0) |=> ((pend_q & $past(clr_i & ~src_evt_i)) == '0));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_we_i |=> $stable(en_q));

endmodule

// File: rtl/avec_prio_enc.sv
module avec_prio_enc #(
  parameter int          NUM_SRC  = 14,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  VEC_BASE = 8'h80,
  parameter logic [7:0]  VEC_STEP = 8'h04
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               any_o,
  output logic [DATA_W-1:0]  vec_o
);
  import avec_pkg::*;

  logic [NUM_SRC-1:0] live;
  assign live  = pend_i & en_i;
  assign any_o = |live;

  // Scan from the lowest priority up, so the lowest set index wins last.
  always_comb begin
    vec_o = DATA_W'(VEC_BASE);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) vec_o = DATA_W'(slot_vector(VEC_BASE, VEC_STEP, i));
    end
  end

  // R9
  always_comb begin
    if (!any_o) idle_vec_chk: assert (vec_o == DATA_W'(VEC_BASE));
  end

endmodule

// File: rtl/avec_fetch_mux.sv
module avec_fetch_mux #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] JUMP_ADDR = 16'h0053,
  parameter logic [ADDR_W-1:0] SUB_ADDR  = 16'h0055,
  parameter logic [7:0]        VEC_BASE  = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              av_en_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [DATA_W-1:0] vec_i,
  output logic [DATA_W-1:0] fetch_data_o
);
  import avec_pkg::*;

  logic [DATA_W-1:0] vec_q;
  logic [DATA_W-1:0] data_q;
  logic              cap;
  fetch_sel_e        sel;

  assign cap = fetch_valid_i && (fetch_addr_i == JUMP_ADDR);
  assign sel = (fetch_valid_i && av_en_i && (fetch_addr_i == SUB_ADDR)) ? FSEL_VEC : FSEL_MEM;

  always_ff @(posedge clk) begin
    if (rst)      vec_q <= DATA_W'(VEC_BASE);
    else if (cap) vec_q <= vec_i;
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= (sel == FSEL_VEC) ? vec_q : mem_data_i;
  end

  assign fetch_data_o = data_q;

  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(vec_q));

  // R11
  pass_off_chk: assert property (@(posedge clk) disable iff (rst)
    !av_en_i |=> (fetch_data_o == $past(mem_data_i)));

  // R12
  pass_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_addr_i != SUB_ADDR) |=> (fetch_data_o == $past(mem_data_i)));

endmodule

// File: rtl/avec_irq_top.sv
module avec_irq_top #(
  parameter int                NUM_SRC   = 14,
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [7:0]        VEC_BASE  = 8'h80,
  parameter logic [7:0]        VEC_STEP  = 8'h04,
  parameter logic [ADDR_W-1:0] JUMP_ADDR = 16'h0053,
  parameter logic [ADDR_W-1:0] SUB_ADDR  = 16'h0055
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               av_en_i,
  input  logic               fetch_valid_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  input  logic [DATA_W-1:0]  mem_data_i,
  output logic               irq_o,
  output logic [DATA_W-1:0]  fetch_data_o
);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] en;
  logic               any_live;
  logic [DATA_W-1:0]  vec;
  logic               irq_q;

  avec_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .src_evt_i  (src_evt_i),
    .clr_i      (clr_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .pend_o     (pend),
    .en_o       (en)
  );

  avec_prio_enc #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP)
  ) u_enc (
    .pend_i (pend),
    .en_i   (en),
    .any_o  (any_live),
    .vec_o  (vec)
  );

  avec_fetch_mux #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .JUMP_ADDR(JUMP_ADDR),
    .SUB_ADDR (SUB_ADDR),
    .VEC_BASE (VEC_BASE)
  ) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .av_en_i      (av_en_i),
    .fetch_valid_i(fetch_valid_i),
    .fetch_addr_i (fetch_addr_i),
    .mem_data_i   (mem_data_i),
    .vec_i        (vec),
    .fetch_data_o (fetch_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_live;
  end

  assign irq_o = irq_q;

  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past((pend & en) != '0)));

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & en) == '0) |=> !irq_o);

endmodule

// File: tb/avec_irq_top_tb.sv
module avec_irq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] src_evt, clr, en_wdata;
  logic        en_we, av_en, fvalid;
  logic [15:0] faddr;
  logic [7:0]  mdata;
  logic        irq;
  logic [7:0]  fdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  avec_irq_top dut_i (
    .clk(clk), .rst(rst), .src_evt_i(src_evt), .clr_i(clr),
    .en_we_i(en_we), .en_wdata_i(en_wdata), .av_en_i(av_en),
    .fetch_valid_i(fvalid), .fetch_addr_i(faddr), .mem_data_i(mdata),
    .irq_o(irq), .fetch_data_o(fdata)
  );

  // Each row holds {events, enables, expected vector, expected irq}.
  localparam logic [36:0] TAB [0:7] = '{
    {14'h0001, 14'h3FFF, 8'h80, 1'b1},
    {14'h2000, 14'h3FFF, 8'hB4, 1'b1},
    {14'h2010, 14'h3FFF, 8'h90, 1'b1},
    {14'h0011, 14'h3FFE, 8'h90, 1'b1},
    {14'h0F00, 14'h3FFF, 8'hA0, 1'b1},
    {14'h3FFF, 14'h0800, 8'hAC, 1'b1},
    {14'h0000, 14'h3FFF, 8'h80, 1'b0},
    {14'h1000, 14'h1000, 8'hB0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    src_evt = '0; clr = '0; en_we = 1'b0; fvalid = 1'b0; faddr = '0; mdata = '0;
  endtask

  // Present one fetch; the registered byte is read at the next falling edge.
  task automatic fetch(input logic [15:0] a, input logic [7:0] m, output logic [7:0] got);
    @(negedge clk);
    src_evt = '0; clr = '0; en_we = 1'b0;
    fvalid = 1'b1; faddr = a; mdata = m;
    @(negedge clk);
    got = fdata;
    fvalid = 1'b0; faddr = '0; mdata = '0;
  endtask

  // Clear all pending bits, load the enables, then pulse the events.
  task automatic load(input logic [13:0] ev, input logic [13:0] en);
    @(negedge clk);
    fvalid = 1'b0; clr = 14'h3FFF; en_we = 1'b1; en_wdata = en; src_evt = '0;
    @(negedge clk);
    clr = '0; en_we = 1'b0; src_evt = ev;
    @(negedge clk);
    src_evt = '0;
    @(negedge clk);
  endtask

  logic [7:0] got;

  initial begin
    rst = 1'b1; src_evt = '0; clr = '0; en_we = 1'b0; en_wdata = '0;
    av_en = 1'b0; fvalid = 1'b0; faddr = '0; mdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R13: reset state
    check("R13 irq after reset", {7'd0, irq}, 8'h00);
    av_en = 1'b1;
    fetch(16'h0055, 8'h3C, got);
    check("R13 reset vector", got, 8'h80);

    // Table walk, covering R1 R2 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 8; k++) begin
      load(TAB[k][36:23], TAB[k][22:9]);
      check("R4 R5 irq per row", {7'd0, irq}, {7'd0, TAB[k][0]});
      fetch(16'h0053, 8'h02, got);
      check("R12 entry fetch passes", got, 8'h02);
      fetch(16'h0055, 8'h5A, got);
      check("R1 R8 vector per row", got, TAB[k][8:1]);
    end

    // R12: page byte passes with autovectoring on
    fetch(16'h0054, 8'h21, got);
    check("R12 page byte", got, 8'h21);

    // R11: autovectoring off passes memory byte at 0x0055
    load(14'h0020, 14'h3FFF);
    av_en = 1'b0;
    fetch(16'h0053, 8'h02, got);
    fetch(16'h0055, 8'h77, got);
    check("R11 pass when off", got, 8'h77);
    av_en = 1'b1;

    // R10: a higher-priority event after the capture does not change the byte
    load(14'h0020, 14'h3FFF);
    fetch(16'h0053, 8'h02, got);
    @(negedge clk); src_evt = 14'h0001;
    @(negedge clk); src_evt = '0;
    fetch(16'h0055, 8'h00, got);
    check("R10 latched vector", got, 8'h94);
    fetch(16'h0053, 8'h02, got);
    fetch(16'h0055, 8'h00, got);
    check("R7 recapture", got, 8'h80);

    // R2: set wins over a clear in the same cycle
    load(14'h0000, 14'h0008);
    @(negedge clk); src_evt = 14'h0008; clr = 14'h0008;
    @(negedge clk); src_evt = '0; clr = '0;
    @(negedge clk);
    check("R2 set beats clear", {7'd0, irq}, 8'h01);

    // R3: clearing drops the request
    @(negedge clk); clr = 14'h0008;
    @(negedge clk); clr = '0;
    @(negedge clk);
    check("R3 clear drops irq", {7'd0, irq}, 8'h00);

    // R5 R6: a pending source raises irq once its enable bit is written
    @(negedge clk); en_we = 1'b1; en_wdata = 14'h0000; src_evt = 14'h0100;
    @(negedge clk); en_we = 1'b0; src_evt = '0;
    @(negedge clk);
    check("R5 masked pending", {7'd0, irq}, 8'h00);
    @(negedge clk); en_we = 1'b1; en_wdata = 14'h0100;
    @(negedge clk); en_we = 1'b0;
    @(negedge clk);
    check("R6 enable write", {7'd0, irq}, 8'h01);
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule